// File: doc/BRIEF.md
# Two-Rail Ternary Line Decoder

This block turns a received pseudo-ternary signal, delivered as two single-bit rails (one rail carries positive marks, the other negative marks), back into a plain NRZ bit stream. A two-bit mode input selects one of four line codes. In plain alternate-mark-inversion mode every mark decodes to a one. The three zero-substitution modes are 8-zero substitution, 6-zero substitution and high-density 3-zero substitution. In those modes the block recognises the substitution patterns that an encoder inserts in place of long zero runs and turns them back into zeros. Any other departure from the code's polarity rules raises an error flag that is aligned with the offending bit.

Decoding uses a short window of recent symbols. Each symbol leaves the window after a fixed delay. At that point it is either part of a recognised pattern, and decodes to zero, or it is judged on its own against the polarity of the previous mark. Only relative polarity is ever used, so it does not matter which physical line feeds which rail. A combinational regenerated-clock output gives the OR of the received rails, or, in loop-test mode, the OR of the local encoder's output rails.

Top module: `ternary_line_decoder`

## Requirements
- R1: The mode input selects the code: 00 alternate mark inversion, 01 8-zero substitution, 10 6-zero substitution, 11 3-zero substitution. A single-rail mark decodes to 1 and a symbol with both rails low decodes to 0, unless it belongs to a recognised pattern.
- R2: The rails are sampled on the rising clock edge. The decoded bit and its error flag appear on `nrz_out`/`code_err` 8 rising edges after sampling. During reset, and for the first 8 edges after it, both outputs are 0.
- R3: When no pattern applies, a mark with the same polarity as the previous mark sets `code_err` to 1 in its output cycle, and `nrz_out` still shows 1. Mode 00 recognises no patterns.
- R4: In mode 01, take P as the polarity of the last mark before the group. The 8-symbol group 0,0,0,P,P̄,0,P̄,P decodes to eight zeros with no error.
- R5: In mode 10, the 6-symbol group 0,P,P̄,0,P̄,P (P as in R4) decodes to six zeros with no error.
- R6: In mode 11, the 4-symbol groups 0,0,0,P and P̄,0,0,P̄ decode to four zeros with no error.
- R7: A same-polarity mark that is not part of a group valid for the current mode is flagged as in R3. An example is a mode-01 group received in mode 00.
- R8: A symbol with both rails high decodes to 1 with `code_err` 1, and it leaves the tracked polarity of the previous mark unchanged.
- R9: Exchanging the two rails leaves `nrz_out` and `code_err` unchanged for any symbol stream.
- R10: `rclk` equals `rail_p | rail_n` when `loop_test` is 0, and `tx_p | tx_n` when `loop_test` is 1, with no clocking.
- R11: After reset, no mark has yet been seen. The first mark is never flagged, and no pattern can be recognised before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder bit clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Line code select (see R1) |
| rail_p | input | 1 | Received positive-mark rail |
| rail_n | input | 1 | Received negative-mark rail |
| loop_test | input | 1 | Selects the encoder rails as the `rclk` source |
| tx_p | input | 1 | Local encoder positive output rail |
| tx_n | input | 1 | Local encoder negative output rail |
| nrz_out | output | 1 | Decoded NRZ data |
| code_err | output | 1 | Code violation flag for the bit on `nrz_out` |
| rclk | output | 1 | Regenerated clock (OR of the selected rail pair) |

## Verification
The clocked properties assume that `mode` is held steady while a substitution group passes through the window. They also assume that the rails change only between clock edges, so a sampled both-high symbol is a real event. The stimulus changes the mode only between groups, with zero symbols separating them, and drives the rails and `mode` on the falling edge. The loop-test source pair is driven directly between edges when `rclk` is checked, because the decoder's data path never observes those inputs.

// File: rtl/tdec_pkg.sv
package tdec_pkg;

    typedef enum logic [1:0] {
        LM_AMI  = 2'b00,
        LM_B8   = 2'b01,
        LM_B6   = 2'b10,
        LM_HDB3 = 2'b11
    } line_mode_e;

    // One received symbol: mark present, negative polarity, both rails high
    typedef struct packed {
        logic mark;
        logic neg;
        logic bad;
    } tsym_t;

    localparam int unsigned B8_SPAN = 8;
    localparam int unsigned B6_SPAN = 6;
    localparam int unsigned HD_SPAN = 4;
    localparam int unsigned MAX_SPAN = 8;

endpackage

// File: rtl/tdec_slicer.sv
module tdec_slicer
    import tdec_pkg::*;
(
    input  logic  rail_p,
    input  logic  rail_n,
    output tsym_t sym
);
    always_comb begin
        sym.mark = rail_p | rail_n;
        sym.bad  = rail_p & rail_n;
        sym.neg  = rail_n & ~rail_p;
    end
endmodule

// File: rtl/tdec_window.sv
module tdec_window
    import tdec_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  tsym_t                  sym_in,
    output tsym_t [DEPTH-1:0]      win
);
    tsym_t [DEPTH-1:0] win_d, win_q;

    always_comb begin
        win_d[0] = sym_in;
        for (int i = 1; i < DEPTH; i++) begin
            win_d[i] = win_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign win = win_q;
endmodule

// File: rtl/tdec_subst_match.sv
module tdec_subst_match
    import tdec_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int KW = $clog2(DEPTH)
) (
    input  tsym_t [DEPTH-1:0] win,
    input  line_mode_e        mode,
    input  logic              last_neg,
    input  logic              seen,
    output logic              hit,
    output logic [KW-1:0]     span
);
    // Per-position class of the oldest symbols, k = 0 is the oldest
    logic [MAX_SPAN-1:0] zv, sv, ov;

    for (genvar k = 0; k < MAX_SPAN; k++) begin : g_cls
        localparam int IDX = DEPTH - 1 - k;
        logic clean;
        assign clean = win[IDX].mark & ~win[IDX].bad;
        assign zv[k] = ~win[IDX].mark & ~win[IDX].bad;
        assign sv[k] = clean & (win[IDX].neg == last_neg);
        assign ov[k] = clean & (win[IDX].neg != last_neg);
    end

    logic b8_hit, b6_hit, hd_hit;

    always_comb begin
        b8_hit = zv[0] & zv[1] & zv[2] & sv[3] & ov[4] & zv[5] & ov[6] & sv[7];
        b6_hit = zv[0] & sv[1] & ov[2] & zv[3] & ov[4] & sv[5];
        hd_hit = (zv[0] & zv[1] & zv[2] & sv[3]) |
                 (ov[0] & zv[1] & zv[2] & ov[3]);
        hit  = 1'b0;
        span = '0;
        if (seen) begin
            case (mode)
                LM_B8: begin
                    hit  = b8_hit;
                    span = KW'(B8_SPAN - 1);
                end
                LM_B6: begin
                    hit  = b6_hit;
                    span = KW'(B6_SPAN - 1);
                end
                LM_HDB3: begin
                    hit  = hd_hit;
                    span = KW'(HD_SPAN - 1);
                end
                default: begin
                    hit  = 1'b0;
                    span = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/ternary_line_decoder.sv
module ternary_line_decoder
    import tdec_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       rail_p,
    input  logic       rail_n,
    input  logic       loop_test,
    input  logic       tx_p,
    input  logic       tx_n,
    output logic       nrz_out,
    output logic       code_err,
    output logic       rclk
);
    localparam int KW = $clog2(DEPTH);

    typedef struct packed {
        logic [KW-1:0] kill;
        logic          last_neg;
        logic          seen;
        logic          nrz;
        logic          err;
    } dec_st_t;

    tsym_t             sym;
    tsym_t [DEPTH-1:0] win;
    logic              hit;
    logic [KW-1:0]     span;
    dec_st_t           st_d, st_q;
    logic [KW-1:0]     kill_cnt;

    tdec_slicer u_slicer (
        .rail_p (rail_p),
        .rail_n (rail_n),
        .sym    (sym)
    );

    tdec_window #(.DEPTH(DEPTH)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .sym_in (sym),
        .win    (win)
    );

    tdec_subst_match #(.DEPTH(DEPTH)) u_match (
        .win      (win),
        .mode     (line_mode_e'(mode)),
        .last_neg (st_q.last_neg),
        .seen     (st_q.seen),
        .hit      (hit),
        .span     (span)
    );

    always_comb begin
        tsym_t old;
        logic  in_pat;
        st_d   = st_q;
        old    = win[DEPTH-1];
        in_pat = 1'b0;
        if (st_q.kill != '0) begin
            in_pat    = 1'b1;
            st_d.kill = st_q.kill - 1'b1;
        end else if (hit) begin
            in_pat    = 1'b1;
            st_d.kill = span;
        end
        if (in_pat) begin
            st_d.nrz = 1'b0;
            st_d.err = 1'b0;
        end else begin
            st_d.nrz = old.mark;
            st_d.err = old.bad |
                       (old.mark & ~old.bad & st_q.seen & (old.neg == st_q.last_neg));
        end
        if (old.mark && !old.bad) begin
            st_d.last_neg = old.neg;
            st_d.seen     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign kill_cnt = st_q.kill;
    assign nrz_out  = st_q.nrz;
    assign code_err = st_q.err;
    assign rclk     = loop_test ? (tx_p | tx_n) : (rail_p | rail_n);
endmodule

// File: rtl/ternary_line_decoder_chk.sv
module ternary_line_decoder_chk #(
    parameter int DEPTH = 8,
    localparam int KW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic          rail_p,
    input logic          rail_n,
    input logic          loop_test,
    input logic          tx_p,
    input logic          tx_n,
    input logic          nrz_out,
    input logic          code_err,
    input logic          rclk,
    input logic [KW-1:0] kill_cnt
);
    logic [DEPTH-1:0] dbl_q;
    logic [CW-1:0]    age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbl_q <= '0;
            age_q <= '0;
        end else begin
            dbl_q <= {dbl_q[DEPTH-2:0], rail_p & rail_n};
            if (age_q != CW'(DEPTH)) age_q <= age_q + 1'b1;
        end
    end

    assert_dbl_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_q[DEPTH-1] |=> (code_err && nrz_out));

    assert_group_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_cnt != '0) |=> (!nrz_out && !code_err));

    assert_ami_nogroup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && kill_cnt == '0) |=> (kill_cnt == '0));

    assert_startup_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q < CW'(DEPTH)) |=> (!nrz_out && !code_err));

    assert_rclk_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_test && (rail_p || rail_n)) |-> rclk);

    assert_rclk_loop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_test && !tx_p && !tx_n) |-> !rclk);
endmodule

bind ternary_line_decoder ternary_line_decoder_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .rail_p    (rail_p),
    .rail_n    (rail_n),
    .loop_test (loop_test),
    .tx_p      (tx_p),
    .tx_n      (tx_n),
    .nrz_out   (nrz_out),
    .code_err  (code_err),
    .rclk      (rclk),
    .kill_cnt  (kill_cnt)
);

// File: tb/sim_ternary_line_decoder.sv
module sim_ternary_line_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       rail_p = 1'b0, rail_n = 1'b0;
    logic       loop_test = 1'b0, tx_p = 1'b0, tx_n = 1'b0;
    logic       nrz_out, code_err, rclk;

    ternary_line_decoder #(.DEPTH(8)) u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .rail_p(rail_p), .rail_n(rail_n),
        .loop_test(loop_test), .tx_p(tx_p), .tx_n(tx_n),
        .nrz_out(nrz_out), .code_err(code_err), .rclk(rclk)
    );

    always #10 clk = ~clk;

    int    checks = 0, fails = 0;
    string cur_req = "R1";
    int    symp[$], symn[$], symm[$];
    int    pe = 0;
    bit    m_seen = 0, m_last = 0;
    int    m_kill = 0;
    bit    bneg = 1;
    bit    swap = 0;
    bit    capturing = 0;
    int    capq[$];

    function automatic byte cls(int e, bit l);
        if (symp[e] != 0 && symn[e] != 0) return "X";
        if (symp[e] == 0 && symn[e] == 0) return "0";
        return ((symn[e] != 0) == l) ? "S" : "O";
    endfunction

    function automatic bit fits(int e, bit l, string pt);
        for (int i = 0; i < pt.len(); i++) begin
            if (cls(e + i, l) != pt[i]) return 0;
        end
        return 1;
    endfunction

    function automatic int group_len(int e, int md, bit l);
        if (md == 1 && fits(e, l, "000SO0OS")) return 8;
        if (md == 2 && fits(e, l, "0SO0OS")) return 6;
        if (md == 3 && (fits(e, l, "000S") || fits(e, l, "O00O"))) return 4;
        return 0;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_and_compare();
        int e, md, len;
        bit enrz, eerr, mk, bd, ng;
        e = pe - 1;
        md = symm[pe + 7];
        enrz = 0; eerr = 0;
        mk = (symp[e] != 0) || (symn[e] != 0);
        bd = (symp[e] != 0) && (symn[e] != 0);
        ng = (symn[e] != 0) && (symp[e] == 0);
        if (m_kill > 0) begin
            m_kill--;
        end else begin
            len = m_seen ? group_len(e, md, m_last) : 0;
            if (len > 0) begin
                m_kill = len - 1;
            end else begin
                enrz = mk;
                eerr = bd || (mk && !bd && m_seen && ng == m_last);
            end
        end
        if (mk && !bd) begin
            m_last = ng;
            m_seen = 1;
        end
        check(nrz_out == enrz && code_err == eerr, cur_req, "nrz/err",
              {nrz_out, code_err}, {enrz, eerr});
        if (capturing) capq.push_back({nrz_out, code_err});
    endtask

    task automatic tick(bit p, bit n);
        rail_p = swap ? n : p;
        rail_n = swap ? p : n;
        symp.push_back(rail_p);
        symn.push_back(rail_n);
        symm.push_back(mode);
        @(negedge clk);
        pe++;
        model_and_compare();
    endtask

    task automatic s0(); tick(0, 0); endtask
    task automatic sm(); bneg = ~bneg; tick(!bneg, bneg); endtask
    task automatic sv(); tick(!bneg, bneg); endtask
    task automatic sboth(); tick(1, 1); endtask
    task automatic zeros(int k); for (int i = 0; i < k; i++) s0(); endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; rail_p = 0; rail_n = 0;
        repeat (3) @(negedge clk);
        check(nrz_out == 0 && code_err == 0, "R2", "outputs in reset",
              {nrz_out, code_err}, 0);
        symp.delete(); symn.delete(); symm.delete();
        for (int i = 0; i < 8; i++) begin
            symp.push_back(0); symn.push_back(0); symm.push_back(0);
        end
        pe = 0; m_seen = 0; m_last = 0; m_kill = 0; bneg = 1;
        rst_n = 1;
    endtask

    task automatic rand_ami(int k);
        for (int i = 0; i < k; i++) begin
            if ($urandom % 2) sm(); else s0();
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int ref_q[$];
        do_reset();
        // R11: first mark after reset, preceded by a 3-zero run, in 3-zero mode
        mode = 2'b11; cur_req = "R11";
        zeros(3); sv(); s0(); sm(); zeros(9);
        // R1 and R2: plain alternate-mark data in mode 00, checked every cycle
        mode = 2'b00; cur_req = "R1";
        sm(); s0(); sm(); sm(); s0(); s0(); sm();
        cur_req = "R2"; rand_ami(40); zeros(9);
        // R3: same-polarity marks in mode 00
        cur_req = "R3"; sm(); s0(); sv(); sm(); sv(); zeros(9);
        // R7: an 8-zero substitution group received in mode 00
        cur_req = "R7"; sm(); s0(); s0(); s0(); sv(); sm(); s0(); sv(); sm(); zeros(9);
        // R4: 8-zero substitution groups
        mode = 2'b01; cur_req = "R4";
        sm(); s0(); s0(); s0(); sv(); sm(); s0(); sv(); sm(); sm();
        s0(); s0(); s0(); sv(); sm(); s0(); sv(); sm(); rand_ami(30); zeros(9);
        // R7: a 3-zero group in mode 01 is a violation
        cur_req = "R7"; sm(); s0(); s0(); s0(); sv(); sm(); zeros(9);
        // R5: 6-zero substitution groups
        mode = 2'b10; cur_req = "R5";
        sm(); s0(); sv(); sm(); s0(); sv(); sm(); sm();
        s0(); sv(); sm(); s0(); sv(); sm(); rand_ami(30); zeros(9);
        // R6: both 3-zero group forms
        mode = 2'b11; cur_req = "R6";
        sm(); s0(); s0(); s0(); sv(); sm(); sm(); s0(); s0(); sv();
        sm(); s0(); s0(); s0(); sv(); rand_ami(30); zeros(9);
        // R8: both rails high, polarity tracker untouched
        cur_req = "R8"; sm(); sboth(); sm(); s0(); sboth(); sv(); zeros(9);
        // R9: the same stream with the rails exchanged
        cur_req = "R9";
        do_reset(); mode = 2'b11; capturing = 1; capq.delete();
        sm(); s0(); s0(); s0(); sv(); sm(); sv(); sm(); s0(); s0(); sv(); sboth(); zeros(10);
        ref_q = capq;
        do_reset(); swap = 1; capq.delete();
        sm(); s0(); s0(); s0(); sv(); sm(); sv(); sm(); s0(); s0(); sv(); sboth(); zeros(10);
        swap = 0; capturing = 0;
        check(capq == ref_q, "R9", "swapped stream output count", capq.size(), ref_q.size());
        // R10: regenerated clock source selection
        cur_req = "R10";
        rail_p = 0; rail_n = 1; tx_p = 0; tx_n = 0; loop_test = 0; #1;
        check(rclk == 1, "R10", "rclk line rails", rclk, 1);
        loop_test = 1; #1;
        check(rclk == 0, "R10", "rclk loop rails idle", rclk, 0);
        tx_p = 1; #1;
        check(rclk == 1, "R10", "rclk loop tx_p", rclk, 1);
        rail_n = 0; tx_p = 0; tx_n = 1; #1;
        check(rclk == 1, "R10", "rclk loop tx_n", rclk, 1);
        loop_test = 0; tx_n = 1; #1;
        check(rclk == 0, "R10", "rclk line rails idle", rclk, 0);
        tx_n = 0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule